// File: doc/BRIEF.md
# BCD Real-Time Clock Register Bank

This block is a memory-mapped time-of-day counter. It holds thirty-two byte-wide registers, and several of them keep the time in packed BCD. A millisecond strobe enters a divide-by-ten prescaler. Each output pulse of the prescaler adds one to the hundredths-of-second register. When a register wraps, it carries into the next one: hundredths into seconds, seconds into minutes, minutes into hours, and hours into the day. The day register counts without limit. Month and year are plain storage and never change on their own.

Software reaches the registers through a 32-bit, word-addressed port. Writes take only the low byte of the data word. A read returns the addressed byte, zero-extended, on the cycle after the address is presented. Software can also capture the running time. It writes a command byte with its top bit set while the control register's top bit is clear. Seconds, minutes, hours, day and month are then copied, in that order, into five shadow registers. These can be read back at leisure while the clock keeps running.

Register indices used by the block:

| Index | Contents |
|-------|----------|
| 0x00 | control; bit 7 set blocks the snapshot |
| 0x04 | command; a write with bit 7 set takes a snapshot |
| 0x05 | hundredths |
| 0x06 | seconds |
| 0x07 | minutes |
| 0x08 | hours |
| 0x09 | day |
| 0x0A | month |
| 0x0B | year |
| 0x0E | day-of-week |
| 0x19 to 0x1D | snapshot copies of seconds, minutes, hours, day and month |

Top module: `rtcb_top`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers, the prescaler and the read data to zero.
- R2: A write to word address 0x380+i (i in 0..31) stores bus_wdata[7:0] into register i. A read of that address returns {24'b0, register i} on bus_rdata in the following cycle.
- R3: Word addresses outside 0x380..0x39F are ignored on write and read back as zero, so none of them aliases a register.
- R4: Hundredths (index 0x05) advances only on the clock edge that samples every tenth tick pulse; the prescaler then restarts from zero. Cycles without a tick leave the time unchanged.
- R5: Every counting field steps in packed BCD. When the low nibble would become 0xA, it clears to 0 and the high nibble increments, for example 0x09 becomes 0x10.
- R6: Hundredths wraps from 0x99 to 0x00 and carries into seconds (0x06). Seconds and minutes (0x07) wrap from 0x59 to 0x00 and carry onward. A field that receives no carry keeps its value.
- R7: Hours (0x08) wraps from 0x23 to 0x00 and increments day (0x09). Day does not wrap and never changes month (0x0A).
- R8: A write to index 0x04 with bit 7 set, while register 0x00 bit 7 is clear, copies seconds, minutes, hours, day and month (0x06..0x0A) into 0x19..0x1D. The copy takes the values held before that edge, and the command byte itself is stored in 0x04.
- R9: No snapshot happens when the written bit 7 is clear or when register 0x00 bit 7 is set. Register 0x04 still stores the written byte.
- R10: When a write and a tick carry target the same field in the same cycle, the written byte wins. Carries to other fields are computed from the value held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle base time strobe (nominally every 1 ms) |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 14 | Word address; the register window is 0x380..0x39F |
| bus_wdata | input | 32 | Write data; only bits 7:0 are stored |
| bus_rdata | output | 32 | Registered read data, the zero-extended addressed byte or zero |

## Verification
The assertions assume three things about the inputs. The tick input is a single-cycle strobe, sampled only on clock edges. At most one register write arrives per cycle. Time fields hold legal packed BCD whenever the carry checks apply. The stimulus keeps within these assumptions: it writes only valid BCD values to the time fields before counting, and it drives every tick as a one-cycle pulse. Every carry scenario is delivered in whole groups of ten ticks, so the prescaler phase is known at each literal check. The one exception is the collision case, which places the tenth tick deliberately in the cycle of a write.

// File: rtl/rtcb_pkg.sv
`timescale 1ns/1ps
package rtcb_pkg;
  localparam int NREG    = 32;
  localparam int REG_W   = 8;
  localparam int IDX_W   = $clog2(NREG);
  localparam int IX_CTRL = 0;
  localparam int IX_CMD  = 4;
  localparam int IX_HUND = 5;
  localparam int IX_SEC  = 6;
  localparam int IX_DAY  = 9;
  localparam int IX_SNAP = 25;
  localparam int NSNAP   = 5;     // seconds .. month
  localparam int NWRAP   = 4;     // hundredths, seconds, minutes, hours

  // value after which a wrapping field returns to zero (as stepped result)
  function automatic logic [REG_W-1:0] wrap_limit(input int f);
    case (f)
      0:       return 8'hA0;
      1, 2:    return 8'h60;
      default: return 8'h24;
    endcase
  endfunction

  // one packed-BCD increment without wrap
  function automatic logic [REG_W-1:0] bcd_step(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] s;
    s = v + 8'd1;
    if (s[3:0] == 4'hA) s = {v[7:4] + 4'd1, 4'h0};
    return s;
  endfunction
endpackage

// File: rtl/rtcb_prescaler.sv
`timescale 1ns/1ps
module rtcb_prescaler #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic adv
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign adv = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (adv)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtcb_bcd_field.sv
`timescale 1ns/1ps
module rtcb_bcd_field
  import rtcb_pkg::*;
#(
  parameter logic [REG_W-1:0] LIMIT = 8'h60
) (
  input  logic [REG_W-1:0] cur,
  input  logic             cin,
  output logic [REG_W-1:0] nxt,
  output logic             cout
);
  logic [REG_W-1:0] stepped;
  logic             at_lim;

  always_comb begin
    stepped = bcd_step(cur);
    at_lim  = (stepped == LIMIT);
    nxt     = at_lim ? '0 : stepped;
    cout    = cin && at_lim;
  end
endmodule

// File: rtl/rtcb_top.sv
`timescale 1ns/1ps
module rtcb_top
  import rtcb_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_WORD = 14'h0380,
  parameter int TICK_DIV = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [REG_W-1:0] regs [NREG];
  logic             adv;
  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic             wr_go;
  logic             snap_go;
  logic [NWRAP:0]   carry;
  logic [REG_W-1:0] fnext [NWRAP];
  logic [REG_W-1:0] day_next;

  // address decode: window is NREG words aligned on its own size
  assign in_win  = (bus_addr[ADDR_W-1:IDX_W] == BASE_WORD[ADDR_W-1:IDX_W]);
  assign idx     = bus_addr[IDX_W-1:0];
  assign wr_go   = bus_we && in_win;
  assign snap_go = wr_go && (idx == IDX_W'(IX_CMD)) && bus_wdata[7]
                   && !regs[IX_CTRL][7];

  rtcb_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .adv (adv)
  );

  // carry cascade over the wrapping fields
  assign carry[0] = adv;
  for (genvar f = 0; f < NWRAP; f++) begin : g_field
    rtcb_bcd_field #(.LIMIT(wrap_limit(f))) u_fld (
      .cur (regs[IX_HUND+f]),
      .cin (carry[f]),
      .nxt (fnext[f]),
      .cout(carry[f+1])
    );
  end
  assign day_next = bcd_step(regs[IX_DAY]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int f = 0; f < NWRAP; f++)
        if (carry[f]) regs[IX_HUND+f] <= fnext[f];
      if (carry[NWRAP]) regs[IX_DAY] <= day_next;
      if (snap_go)
        for (int k = 0; k < NSNAP; k++) regs[IX_SNAP+k] <= regs[IX_SEC+k];
      if (wr_go) regs[idx] <= bus_wdata[REG_W-1:0];   // bus wins (last)
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (in_win) bus_rdata <= {{(DATA_W-REG_W){1'b0}}, regs[idx]};
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/rtcb_checker.sv
`timescale 1ns/1ps
module rtcb_checker
  import rtcb_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_WORD = 14'h0380
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              adv,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  wlow,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [REG_W-1:0]  regs [NREG]
);
  logic             c_win;
  logic [IDX_W-1:0] c_idx;
  assign c_win = (bus_addr[ADDR_W-1:IDX_W] == BASE_WORD[ADDR_W-1:IDX_W]);
  assign c_idx = bus_addr[IDX_W-1:0];

  // R2
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    bus_we && c_win |=> regs[$past(c_idx)] == $past(wlow));

  // R3
  a_r3_outside_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !c_win |=> bus_rdata == '0);

  // R4
  a_r4_adv_needs_tick: assert property (@(posedge clk) disable iff (rst)
    adv |-> tick);

  // R4
  a_r4_idle_holds_time: assert property (@(posedge clk) disable iff (rst)
    !tick && !bus_we |=> $stable(regs[IX_HUND]) && $stable(regs[IX_SEC]));

  // R6
  a_r6_hund_wrap_carry: assert property (@(posedge clk) disable iff (rst)
    adv && !bus_we && regs[IX_HUND] == 8'h99 && regs[IX_SEC] == 8'h00
    |=> regs[IX_HUND] == 8'h00 && regs[IX_SEC] == 8'h01);

  // R8
  a_r8_snapshot_copy: assert property (@(posedge clk) disable iff (rst)
    bus_we && c_win && c_idx == IDX_W'(IX_CMD) && wlow[7] && !regs[IX_CTRL][7]
    |=> regs[IX_SNAP] == $past(regs[IX_SEC]) && regs[IX_SNAP+4] == $past(regs[IX_SEC+4]));

  // R9
  a_r9_locked_no_copy: assert property (@(posedge clk) disable iff (rst)
    regs[IX_CTRL][7] && !(bus_we && c_win && c_idx == IDX_W'(IX_SNAP))
    |=> $stable(regs[IX_SNAP]));

  // R10
  a_r10_bus_beats_tick: assert property (@(posedge clk) disable iff (rst)
    adv && bus_we && c_win && c_idx == IDX_W'(IX_HUND)
    |=> regs[IX_HUND] == $past(wlow));
endmodule

bind rtcb_top rtcb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_WORD(BASE_WORD)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .adv      (adv),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .wlow     (bus_wdata[7:0]),
  .bus_rdata(bus_rdata),
  .regs     (regs)
);

// File: tb/rtcb_top_test.sv
`timescale 1ns/1ps
module rtcb_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [13:0] addr = 14'h0000;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;

  always #5 clk = ~clk;

  rtcb_top uut (
    .clk(clk), .rst(rst), .tick(tick), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    live = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  int unsigned m [32];
  int          presc = 0;
  logic [31:0] exp_rd = 32'h0;

  function automatic int b2i(input int unsigned b);
    return (b / 16) * 10 + (b % 16);
  endfunction
  function automatic int unsigned i2b(input int i);
    return ((i / 10) * 16) + (i % 10);
  endfunction

  task automatic advance();
    int h, s, mi, hr;
    h = b2i(m[5]) + 1;
    if (h == 100) begin
      h = 0;
      s = b2i(m[6]) + 1;
      if (s == 60) begin
        s = 0;
        mi = b2i(m[7]) + 1;
        if (mi == 60) begin
          mi = 0;
          hr = b2i(m[8]) + 1;
          if (hr == 24) begin
            hr = 0;
            m[9] = i2b(b2i(m[9]) + 1);
          end
          m[8] = i2b(hr);
        end
        m[7] = i2b(mi);
      end
      m[6] = i2b(s);
    end
    m[5] = i2b(h);
  endtask

  always @(posedge clk) begin : model
    int unsigned old [32];
    bit inw;
    int ix;
    cyc++;
    if (rst) begin
      for (int i = 0; i < 32; i++) m[i] = 0;
      presc = 0;
      exp_rd = 32'h0;
    end else begin
      old = m;
      inw = (addr >= 14'h380) && (addr <= 14'h39F);
      ix  = int'(addr) - 'h380;
      exp_rd = inw ? old[ix] : 0;
      if (tick) begin
        presc++;
        if (presc == 10) begin
          presc = 0;
          advance();
        end
      end
      if (we && inw) begin
        m[ix] = wdata & 32'hFF;
        if (ix == 4 && wdata[7] && old[0] < 128)
          for (int k = 0; k < 5; k++) m[25 + k] = old[6 + k];
      end
    end
    if (cyc == 50000 && !done) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live) check(rdata === exp_rd, cur_req, "rdata vs model", rdata, exp_rd);
  end

  task automatic step(input bit t, input bit w, input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    tick = t; we = w; addr = a; wdata = d;
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    step(0, 1, 14'h380 + 14'(i), d);
    step(0, 0, addr, 32'h0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1, 0, addr, 32'h0);
      step(0, 0, addr, 32'h0);
    end
  endtask

  task automatic rd(input logic [13:0] a, input logic [31:0] exp, input string req);
    step(0, 0, a, 32'h0);
    @(negedge clk);
    check(rdata === exp, req, $sformatf("read %h", a), rdata, exp);
  endtask

  task automatic rdi(input int i, input logic [31:0] exp, input string req);
    rd(14'h380 + 14'(i), exp, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    live = 1;

    cur_req = "R1";
    for (int i = 0; i < 32; i++) rdi(i, 32'h0, "R1");

    cur_req = "R2";
    wr(16, 32'hDEAD_BEA5); rdi(16, 32'h0000_00A5, "R2");
    wr(31, 32'h0000_003C); rdi(31, 32'h0000_003C, "R2");
    wr(0, 32'h0000_0012);  rdi(0, 32'h0000_0012, "R2");
    wr(0, 32'h0);          rdi(0, 32'h0, "R2");

    cur_req = "R3";
    step(0, 1, 14'h37F, 32'h77);
    step(0, 1, 14'h3A0, 32'h66);
    step(0, 1, 14'h000, 32'h55);
    step(0, 1, 14'h340, 32'h44);
    step(0, 0, 14'h340, 32'h0);
    rd(14'h3A0, 32'h0, "R3");
    rd(14'h37F, 32'h0, "R3");
    rd(14'h340, 32'h0, "R3");
    rdi(0, 32'h0, "R3");
    rdi(31, 32'h3C, "R3");

    cur_req = "R4";
    wr(5, 32'h00);
    ticks(9);
    rdi(5, 32'h00, "R4");
    ticks(1);
    rdi(5, 32'h01, "R4");
    repeat (20) step(0, 0, addr, 32'h0);
    rdi(5, 32'h01, "R4");

    cur_req = "R5";
    wr(5, 32'h09); ticks(10); rdi(5, 32'h10, "R5");
    wr(5, 32'h39); ticks(10); rdi(5, 32'h40, "R5");

    cur_req = "R6";
    wr(5, 32'h99); wr(6, 32'h59); wr(7, 32'h59); wr(8, 32'h05);
    ticks(10);
    rdi(5, 32'h00, "R6"); rdi(6, 32'h00, "R6");
    rdi(7, 32'h00, "R6"); rdi(8, 32'h06, "R6");
    wr(5, 32'h99); wr(6, 32'h15);
    ticks(10);
    rdi(6, 32'h16, "R6"); rdi(7, 32'h00, "R6");

    cur_req = "R7";
    wr(5, 32'h99); wr(6, 32'h59); wr(7, 32'h59); wr(8, 32'h23);
    wr(9, 32'h31); wr(10, 32'h12);
    ticks(10);
    rdi(8, 32'h00, "R7"); rdi(9, 32'h32, "R7"); rdi(10, 32'h12, "R7");

    cur_req = "R8";
    wr(6, 32'h45); wr(7, 32'h32); wr(8, 32'h11); wr(9, 32'h07); wr(10, 32'h09);
    wr(4, 32'h80);
    rdi(25, 32'h45, "R8"); rdi(26, 32'h32, "R8"); rdi(27, 32'h11, "R8");
    rdi(28, 32'h07, "R8"); rdi(29, 32'h09, "R8"); rdi(4, 32'h80, "R8");

    cur_req = "R9";
    wr(6, 32'h50);
    wr(4, 32'h7F);
    rdi(25, 32'h45, "R9"); rdi(4, 32'h7F, "R9");
    wr(0, 32'h80);
    wr(4, 32'h80);
    rdi(25, 32'h45, "R9"); rdi(4, 32'h80, "R9");
    wr(0, 32'h00);

    cur_req = "R10";
    wr(5, 32'h42); wr(6, 32'h10);
    ticks(9);
    step(1, 1, 14'h385, 32'h77);
    step(0, 0, addr, 32'h0);
    rdi(5, 32'h77, "R10");
    rdi(6, 32'h10, "R10");

    live = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule